// File: doc/BRIEF.md
# Shared-Level Interrupt Latch Bank

This block holds one request latch per interrupt priority level and reports which pending level the CPU should serve next. It models eight levels. Level 0 has the highest priority and level 7 the lowest. Levels 0 to 5 each have one dedicated request input. Levels 6 and 7 are each shared by two peripheral sources. A two-bit source selector register decides which of the two sources may set the latch for each shared level. A request from the source that is not selected is dropped on the spot. It is not stored, so it cannot reappear later when the selection changes.

Software reaches the block through a small write port. A write to address 0 loads the source selector. A write to address 1 clears every latch whose bit is 1 in the written data. The CPU sequencer acknowledges the level it accepts, and that acknowledge clears only the latch of that level. A per-level enable mask decides which set latches take part in the priority resolution. Masking a level hides its latch but does not erase it.

Top module: `intLatchBank`

## Requirements
- R1: After reset, all latches are clear, the selector reads 0x00, `pending` is 0 and `topLevel` is 0.
- R2: A 1 on `reqPlain[i]` at a rising clock edge sets the latch of level i (i = 0..5), and the latch is visible on the outputs right after that edge.
- R3: Selector bit 0 chooses the source of level 6. When the bit is 0, `extReq4` sets the level 6 latch. When the bit is 1 (the reserved setting), no request sets the level 6 latch, and a request blocked this way does not show up after the bit returns to 0.
- R4: Selector bit 1 chooses the source of level 7. When the bit is 0, `extReq5` sets the level 7 latch. When the bit is 1, `adcDoneReq` sets it. A request from the unselected source is discarded and does not show up after the selection changes.
- R5: A write with `regAddr`=0 loads `regWrData[1:0]` into the selector. `selRd` returns those two bits, and bits 7..2 of `selRd` always read 0.
- R6: A set latch stays set until an acknowledge or a software clear targets its level.
- R7: `ackValid` with `ackLevel`=k clears the latch of level k only. All other latches keep their state.
- R8: A write with `regAddr`=1 clears every latch whose bit in `regWrData` is 1 and leaves the other latches unchanged.
- R9: When a set request and a clear (software or acknowledge) reach the same latch in the same cycle, the latch ends up set.
- R10: `pending` is 1 exactly when some level has both its latch set and its `enableMask` bit at 1. `topLevel` gives the lowest-numbered such level, or 0 when there is none.
- R11: A latch whose enable bit is 0 stays set but is not reported. It is reported again once its enable bit returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqPlain | input | 6 | Request inputs for levels 0..5 |
| extReq4 | input | 1 | External request 4, first candidate for level 6 |
| extReq5 | input | 1 | External request 5, first candidate for level 7 |
| adcDoneReq | input | 1 | Conversion-done request, second candidate for level 7 |
| enableMask | input | 8 | Per-level enable for priority resolution |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Write target: 0 selects the selector register, 1 selects latch clear |
| regWrData | input | 8 | Write data: selector value or clear mask |
| ackValid | input | 1 | The CPU sequencer accepts a level this cycle |
| ackLevel | input | 3 | Level being accepted |
| pending | output | 1 | Some enabled latch is set |
| topLevel | output | 3 | Lowest-numbered enabled set level |
| selRd | output | 8 | Selector readback, upper bits 0 |

## Verification
The assertions run on every cycle. They check that a set latch survives any cycle in which no clear targets it, and that an acknowledge with no competing request empties the acknowledged latch. They check that the reserved selector setting and the unselected conversion source never set a latch. They also check that `pending` and `topLevel` agree with the enabled latches, and that the unused selector bits read zero. Some behaviours only the bench's scenarios can show, because they depend on history. A dropped request must stay absent after the selector changes. A masked latch must come back when its enable bit returns. A request must win over a simultaneous clear, and `topLevel` must move as higher-priority levels arrive and leave.

// File: rtl/intLatchPkg.sv
package intLatchPkg;
  localparam int LEVELS   = 8;
  localparam int LVL_W    = $clog2(LEVELS);
  localparam int REG_W    = 8;
  localparam int SEL_BITS = 2;
  localparam int PLAIN    = LEVELS - SEL_BITS;
  localparam int LVL_A    = LEVELS - 2;
  localparam int LVL_B    = LEVELS - 1;
  localparam logic ADDR_SEL = 1'b0;
  localparam logic ADDR_CLR = 1'b1;

  typedef struct packed {
    logic [LEVELS-1:0] setMask;
    logic [LEVELS-1:0] clrMask;
  } latchStrobes_t;
endpackage

// File: rtl/intLatchCtrl.sv
module intLatchCtrl
  import intLatchPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [PLAIN-1:0]  reqPlain,
  input  logic              extReq4,
  input  logic              extReq5,
  input  logic              adcDoneReq,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              ackValid,
  input  logic [LVL_W-1:0]  ackLevel,
  output latchStrobes_t     strobes,
  output logic [REG_W-1:0]  selRd
);
  logic [SEL_BITS-1:0] selQ;
  logic [LEVELS-1:0]   setVec;
  logic [LEVELS-1:0]   clrVec;
  logic                swClr;

  // Source selector register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      selQ <= '0;
    else if (regWrEn && regAddr == ADDR_SEL)
      selQ <= regWrData[SEL_BITS-1:0];
  end

  assign swClr = regWrEn && (regAddr == ADDR_CLR);

  // Dedicated levels pass straight through
  assign setVec[PLAIN-1:0] = reqPlain;
  // Shared level A: bit 0 = 0 takes extReq4, bit 0 = 1 is reserved and blocks
  assign setVec[LVL_A] = extReq4 & ~selQ[0];
  // Shared level B: bit 1 picks extReq5 (0) or adcDoneReq (1)
  assign setVec[LVL_B] = selQ[1] ? adcDoneReq : extReq5;

  for (genvar g = 0; g < LEVELS; g++) begin : g_clr
    assign clrVec[g] = (swClr & regWrData[g]) |
                       (ackValid && ackLevel == LVL_W'(g));
  end

  assign strobes = '{setMask: setVec, clrMask: clrVec};
  assign selRd   = {{(REG_W-SEL_BITS){1'b0}}, selQ};
endmodule

// File: rtl/intLatchData.sv
module intLatchData
  import intLatchPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  latchStrobes_t     strobes,
  input  logic [LEVELS-1:0] enableMask,
  output logic [LEVELS-1:0] latchQ,
  output logic              pending,
  output logic [LVL_W-1:0]  topLevel
);
  logic [LEVELS-1:0] latchNext;
  logic [LEVELS-1:0] active;

  // A set request wins over any clear in the same cycle
  for (genvar g = 0; g < LEVELS; g++) begin : g_next
    assign latchNext[g] = strobes.setMask[g] |
                          (latchQ[g] & ~strobes.clrMask[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      latchQ <= '0;
    else
      latchQ <= latchNext;
  end

  assign active  = latchQ & enableMask;
  assign pending = |active;

  // Lowest index wins: scan from the top so lower levels overwrite
  always_comb begin
    topLevel = '0;
    for (int i = LEVELS - 1; i >= 0; i--) begin
      if (active[i]) topLevel = LVL_W'(i);
    end
  end
endmodule

// File: rtl/intLatchBank.sv
module intLatchBank
  import intLatchPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [PLAIN-1:0]  reqPlain,
  input  logic              extReq4,
  input  logic              extReq5,
  input  logic              adcDoneReq,
  input  logic [LEVELS-1:0] enableMask,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              ackValid,
  input  logic [LVL_W-1:0]  ackLevel,
  output logic              pending,
  output logic [LVL_W-1:0]  topLevel,
  output logic [REG_W-1:0]  selRd
);
  latchStrobes_t     strobes;
  logic [LEVELS-1:0] latchVec;

  intLatchCtrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqPlain   (reqPlain),
    .extReq4    (extReq4),
    .extReq5    (extReq5),
    .adcDoneReq (adcDoneReq),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .ackValid   (ackValid),
    .ackLevel   (ackLevel),
    .strobes    (strobes),
    .selRd      (selRd)
  );

  intLatchData i_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .enableMask (enableMask),
    .latchQ     (latchVec),
    .pending    (pending),
    .topLevel   (topLevel)
  );
endmodule

// File: rtl/intLatchChecker.sv
module intLatchChecker
  import intLatchPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [PLAIN-1:0]  reqPlain,
  input logic              extReq4,
  input logic              extReq5,
  input logic              adcDoneReq,
  input logic [LEVELS-1:0] enableMask,
  input logic              regWrEn,
  input logic              regAddr,
  input logic [REG_W-1:0]  regWrData,
  input logic              ackValid,
  input logic [LVL_W-1:0]  ackLevel,
  input logic              pending,
  input logic [LVL_W-1:0]  topLevel,
  input logic [REG_W-1:0]  selRd,
  input logic [LEVELS-1:0] latchVec
);
  logic [LEVELS-1:0] anyClr;
  logic              noReq;

  assign anyClr = ((regWrEn && regAddr == ADDR_CLR) ? regWrData[LEVELS-1:0] : '0) |
                  (ackValid ? (LEVELS'(1) << ackLevel) : '0);
  assign noReq  = (reqPlain == '0) && !extReq4 && !extReq5 && !adcDoneReq;

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(latchVec) & ~$past(anyClr) & ~latchVec) == '0)); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && noReq) |=> !latchVec[$past(ackLevel)]); // R7
  AST_RESERVED_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (selRd[0] && !latchVec[LVL_A] && !(regWrEn && regAddr == ADDR_SEL)) |=> !latchVec[LVL_A]); // R3
  AST_ADC_UNSELECTED: assert property (@(posedge clk) disable iff (!rstN)
    (!selRd[1] && !extReq5 && !latchVec[LVL_B]) |=> !latchVec[LVL_B]); // R4
  AST_PLAIN_SETS: assert property (@(posedge clk) disable iff (!rstN)
    reqPlain[0] |=> latchVec[0]); // R9
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    selRd[REG_W-1:SEL_BITS] == '0); // R5
  AST_TOP_VALID: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> (latchVec[topLevel] && enableMask[topLevel])); // R10
  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    !pending |-> ((latchVec & enableMask) == '0 && topLevel == '0)); // R10
endmodule

bind intLatchBank intLatchChecker i_chk (.*);

// File: tb/test_intLatchBank.sv
module test_intLatchBank;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] reqPlain = '0;
  logic       extReq4 = 1'b0, extReq5 = 1'b0, adcDoneReq = 1'b0;
  logic [7:0] enableMask = 8'hFF;
  logic       regWrEn = 1'b0, regAddr = 1'b0;
  logic [7:0] regWrData = '0;
  logic       ackValid = 1'b0;
  logic [2:0] ackLevel = '0;
  logic       pending;
  logic [2:0] topLevel;
  logic [7:0] selRd;

  int checks = 0;
  int errors = 0;
  bit doneFlag = 1'b0;

  typedef struct {
    logic       pend;
    logic [2:0] top;
    logic [7:0] sel;
    string      tag;
  } expItem_t;
  expItem_t expQ[$];

  always #10 clk = ~clk;

  intLatchBank i_intLatchBank (.*);

  task automatic compare(input expItem_t e);
    checks++;
    if (pending !== e.pend || topLevel !== e.top || selRd !== e.sel) begin
      errors++;
      $display("FAIL %s: got pend=%b top=%0d sel=%h, expected pend=%b top=%0d sel=%h",
               e.tag, pending, topLevel, selRd, e.pend, e.top, e.sel);
    end
  endtask

  // Driver: apply one cycle of stimulus and queue the outcome after the next edge
  task automatic drive(input logic [5:0] rp, input logic e4, input logic e5,
                       input logic adc, input logic [7:0] en, input logic we,
                       input logic wa, input logic [7:0] wd, input logic av,
                       input logic [2:0] al, input logic xp, input logic [2:0] xt,
                       input logic [7:0] xs, input string tag);
    expItem_t e;
    @(negedge clk);
    reqPlain = rp; extReq4 = e4; extReq5 = e5; adcDoneReq = adc;
    enableMask = en; regWrEn = we; regAddr = wa; regWrData = wd;
    ackValid = av; ackLevel = al;
    e.pend = xp; e.top = xt; e.sel = xs; e.tag = tag;
    expQ.push_back(e);
  endtask

  // Monitor: pop one expected item per clock, after the edge has settled
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) compare(expQ.pop_front());
    end
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    expItem_t r;
    #15;
    r.pend = 1'b0; r.top = 3'd0; r.sel = 8'h00; r.tag = "R1 reset state";
    compare(r);
    @(negedge clk); rstN = 1'b1;
    //     rp     e4 e5 adc en     we wa wd     av al    pend top sel
    drive(6'h00, 0, 0, 0, 8'hFF, 0, 0, 8'h00, 0, 3'd0, 0, 3'd0, 8'h00, "R1 idle after reset");
    drive(6'h08, 0, 0, 0, 8'hFF, 0, 0, 8'h00, 0, 3'd0, 1, 3'd3, 8'h00, "R2 plain level 3 set");
    drive(6'h00, 0, 0, 0, 8'hFF, 0, 0, 8'h00, 0, 3'd0, 1, 3'd3, 8'h00, "R6 level 3 held");
    drive(6'h02, 0, 0, 0, 8'hFF, 0, 0, 8'h00, 0, 3'd0, 1, 3'd1, 8'h00, "R10 level 1 outranks 3");
    drive(6'h00, 0, 0, 0, 8'hFF, 0, 0, 8'h00, 1, 3'd1, 1, 3'd3, 8'h00, "R7 ack clears level 1 only");
    drive(6'h00, 0, 0, 0, 8'hF7, 0, 0, 8'h00, 0, 3'd0, 0, 3'd0, 8'h00, "R11 masked level hidden");
    drive(6'h00, 0, 0, 0, 8'hFF, 0, 0, 8'h00, 0, 3'd0, 1, 3'd3, 8'h00, "R11 unmasked level returns");
    drive(6'h00, 0, 0, 0, 8'hFF, 1, 1, 8'h08, 0, 3'd0, 0, 3'd0, 8'h00, "R8 software clear level 3");
    drive(6'h00, 0, 0, 1, 8'hFF, 0, 0, 8'h00, 0, 3'd0, 0, 3'd0, 8'h00, "R4 adc ignored when sel1=0");
    drive(6'h00, 0, 0, 0, 8'hFF, 1, 0, 8'hFE, 0, 3'd0, 0, 3'd0, 8'h02, "R5 selector readback upper zero");
    drive(6'h00, 0, 0, 1, 8'hFF, 0, 0, 8'h00, 0, 3'd0, 1, 3'd7, 8'h02, "R4 adc selected sets level 7");
    drive(6'h00, 0, 0, 1, 8'hFF, 0, 0, 8'h00, 1, 3'd7, 1, 3'd7, 8'h02, "R9 request beats ack");
    drive(6'h00, 0, 1, 0, 8'hFF, 1, 1, 8'h80, 0, 3'd0, 0, 3'd0, 8'h02, "R4 ext5 ignored when sel1=1");
    drive(6'h00, 1, 0, 0, 8'hFF, 0, 0, 8'h00, 0, 3'd0, 1, 3'd6, 8'h02, "R3 ext4 sets level 6");
    drive(6'h20, 0, 0, 0, 8'hFF, 0, 0, 8'h00, 0, 3'd0, 1, 3'd5, 8'h02, "R2 plain level 5 set");
    drive(6'h20, 0, 0, 0, 8'hFF, 1, 1, 8'h60, 0, 3'd0, 1, 3'd5, 8'h02, "R9 request beats software clear");
    drive(6'h00, 0, 0, 0, 8'hFF, 0, 0, 8'h00, 1, 3'd5, 0, 3'd0, 8'h02, "R8 level 6 was cleared too");
    drive(6'h00, 0, 0, 0, 8'hFF, 1, 0, 8'h03, 0, 3'd0, 0, 3'd0, 8'h03, "R5 selector loads 3");
    drive(6'h00, 1, 0, 0, 8'hFF, 0, 0, 8'h00, 0, 3'd0, 0, 3'd0, 8'h03, "R3 reserved setting blocks ext4");
    drive(6'h00, 0, 0, 0, 8'hFF, 1, 0, 8'h00, 0, 3'd0, 0, 3'd0, 8'h00, "R3 blocked request not kept");
    drive(6'h00, 0, 1, 0, 8'hFF, 0, 0, 8'h00, 0, 3'd0, 1, 3'd7, 8'h00, "R4 ext5 selected sets level 7");
    drive(6'h11, 0, 0, 0, 8'hFF, 0, 0, 8'h00, 0, 3'd0, 1, 3'd0, 8'h00, "R10 level 0 is top");
    drive(6'h00, 0, 0, 0, 8'hFE, 0, 0, 8'h00, 0, 3'd0, 1, 3'd4, 8'h00, "R10 next enabled level 4");
    @(negedge clk);
    @(negedge clk);
    doneFlag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule